// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one column command into the sequence of column addresses an SDRAM burst visits. A start strobe loads the first column together with the burst-length code, the wrap-order bit, the single-write override bit and a read/write flag. From the next clock on the block presents one column per cycle, with a valid strobe, and flags the final beat of any burst of finite length.

The sequence can run in two orders. Sequential order counts upward and wraps inside the aligned block of the burst length. Interleaved order XORs the start column with the beat number. A page-length code runs through every column of the row, wraps at the row end and never ends by itself. A stop input and a precharge input end any burst, and a new start on any cycle replaces the running burst. When the single-write override is set, every write burst is one beat long. Read bursts keep the programmed length.

Top module: `sdram_col_gen`

## Requirements
- R1: After reset, valid_o and last_o are 0 and col_o is 0.
- R2: In the cycle after start_i is sampled high, valid_o is 1 and col_o equals the sampled start_col_i. This holds even while a burst is running, and it replaces that burst.
- R3: Length codes are bl_code_i = 000 for 1 beat, 001 for 2, 010 for 4, 011 for 8 and 111 for a full page. Codes 100, 101 and 110 give a 1-beat burst.
- R4: With interleave_i = 0 and a finite length BL, beat k is (start & ~(BL-1)) | ((start + k) mod BL).
- R5: With interleave_i = 1 and a finite length BL, beat k is start XOR k.
- R6: With code 111 the burst walks upward through all 2^COL_W columns, modulo 2^COL_W, and never ends by itself. interleave_i is ignored for this code.
- R7: last_o is 1 together with valid_o on the final beat of a finite burst, and it is never 1 in full-page mode. valid_o drops in the cycle after the final beat unless a new start arrives.
- R8: When write_i = 1 and single_wr_i = 1, the burst is 1 beat whatever the code. Reads, and writes with single_wr_i = 0, keep the programmed length.
- R9: stop_i sampled high during a burst makes valid_o 0 in the next cycle. If start_i is high in the same cycle, start_i wins.
- R10: pre_i sampled high during a burst ends it in the same way as stop_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command strobe; loads the burst |
| start_col_i | input | COL_W | Start column |
| bl_code_i | input | 3 | Burst-length code |
| interleave_i | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| single_wr_i | input | 1 | Forces writes to 1 beat |
| write_i | input | 1 | 1 for a write burst, 0 for a read burst |
| stop_i | input | 1 | Burst stop |
| pre_i | input | 1 | Precharge interrupt |
| col_o | output | COL_W | Current column |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
The assertions check on every cycle that a start loads its column, that stop, precharge and a final beat end the burst, that single-beat cases flag last at once, and that a full-page burst steps by one without ever flagging last. The exact column order of sequential and interleaved bursts at each length, the wrap inside aligned blocks, the wrap across the row end, and restarts in the middle of a burst are shown only by the bench scenarios, which compare every beat against a computed sequence.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  localparam int BL_CODE_W = 3;

  typedef enum logic [BL_CODE_W-1:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  // log2 of finite burst length; reserved codes map to one beat
  function automatic logic [1:0] bl_log2(input logic [BL_CODE_W-1:0] code);
    case (code)
      BL_2:    return 2'd1;
      BL_4:    return 2'd2;
      BL_8:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/sdram_bl_decode.sv
module sdram_bl_decode
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [BL_CODE_W-1:0] bl_code_i,
  input  logic                 interleave_i,
  input  logic                 single_wr_i,
  input  logic                 write_i,
  output logic [COL_W-1:0]     mask_o,
  output logic                 full_o,
  output logic                 il_o
);
  logic       one_beat;
  logic [1:0] lg;

  assign one_beat = write_i & single_wr_i;
  assign lg       = one_beat ? 2'd0 : bl_log2(bl_code_i);
  assign full_o   = (bl_code_i == BL_PAGE) & ~one_beat;
  assign mask_o   = full_o ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << lg);
  // page mode is sequential only
  assign il_o     = interleave_i & ~full_o;
endmodule

// File: rtl/sdram_beat_ctrl.sv
module sdram_beat_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             il_i,
  input  logic             stop_i,
  input  logic             pre_i,
  output logic             act_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output logic             il_o
);
  logic             act_q, full_q, il_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic             last;

  assign last = act_q & ~full_q & (cnt_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      il_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      full_q <= full_i;
      il_q   <= il_i;
      base_q <= start_col_i;
      cnt_q  <= '0;
      mask_q <= mask_i;
    end else if (act_q) begin
      if (stop_i || pre_i || last) act_q <= 1'b0;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o  = act_q;
  assign last_o = last;
  assign base_o = base_q;
  assign cnt_o  = cnt_q;
  assign mask_o = mask_q;
  assign il_o   = il_q;
endmodule

// File: rtl/sdram_col_map.sv
module sdram_col_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + cnt_i;

  // bits above the burst field hold the aligned block
  for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
    assign col_o[gi] = mask_i[gi] ? (il_i ? (base_i[gi] ^ cnt_i[gi]) : sum[gi])
                                  : base_i[gi];
  end
endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdram_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [COL_W-1:0]     start_col_i,
  input  logic [BL_CODE_W-1:0] bl_code_i,
  input  logic                 interleave_i,
  input  logic                 single_wr_i,
  input  logic                 write_i,
  input  logic                 stop_i,
  input  logic                 pre_i,
  output logic [COL_W-1:0]     col_o,
  output logic                 valid_o,
  output logic                 last_o
);
  logic [COL_W-1:0] dec_mask, base, cnt, mask;
  logic             dec_full, dec_il, il;

  sdram_bl_decode #(.COL_W(COL_W)) i_dec (
    .bl_code_i    (bl_code_i),
    .interleave_i (interleave_i),
    .single_wr_i  (single_wr_i),
    .write_i      (write_i),
    .mask_o       (dec_mask),
    .full_o       (dec_full),
    .il_o         (dec_il)
  );

  sdram_beat_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .full_i      (dec_full),
    .il_i        (dec_il),
    .stop_i      (stop_i),
    .pre_i       (pre_i),
    .act_o       (valid_o),
    .last_o      (last_o),
    .base_o      (base),
    .cnt_o       (cnt),
    .mask_o      (mask),
    .il_o        (il)
  );

  sdram_col_map #(.COL_W(COL_W)) i_map (
    .base_i (base),
    .cnt_i  (cnt),
    .mask_i (mask),
    .il_i   (il),
    .col_o  (col_o)
  );
endmodule

// File: rtl/sdram_col_gen_chk.sv
module sdram_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       bl_code_i,
  input logic             interleave_i,
  input logic             single_wr_i,
  input logic             write_i,
  input logic             stop_i,
  input logic             pre_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      page_q <= 1'b0;
    else if (start_i) page_q <= (bl_code_i == 3'b111) && !(write_i && single_wr_i);
  end

  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && (col_o == $past(start_col_i)));  // R2
  AST_RSV_ONE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (bl_code_i == 3'b000 || bl_code_i == 3'b100 || bl_code_i == 3'b101
                || bl_code_i == 3'b110) |=> last_o);  // R3
  AST_PAGE_NO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_q && valid_o |-> !last_o);  // R6
  AST_PAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_q && valid_o && !start_i && !stop_i && !pre_i
      |=> valid_o && (col_o == $past(col_o) + COL_W'(1)));  // R6
  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);  // R7
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o);  // R7
  AST_SW_ONE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && write_i && single_wr_i |=> last_o);  // R8
  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && stop_i && !start_i |=> !valid_o);  // R9
  AST_PRE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && pre_i && !start_i |=> !valid_o);  // R10
endmodule

bind sdram_col_gen sdram_col_gen_chk #(.COL_W(COL_W)) i_chk (.*);

// File: tb/test_sdram_col_gen.sv
module test_sdram_col_gen;
  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       bl_code_i = '0;
  logic             interleave_i = 1'b0;
  logic             single_wr_i = 1'b0;
  logic             write_i = 1'b0;
  logic             stop_i = 1'b0;
  logic             pre_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  sdram_col_gen #(.COL_W(COL_W)) i_sdram_col_gen (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    int    col;
    bit    last;
    string req;
  } beat_t;

  beat_t q[$];
  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bl_of(input logic [2:0] code);
    case (code)
      3'b001:  return 2;
      3'b010:  return 4;
      3'b011:  return 8;
      default: return 1;
    endcase
  endfunction

  // kind: 0 natural end, 1 stop, 2 precharge, 3 leave running (next call restarts)
  task automatic burst(input int sc, input logic [2:0] code, input bit il,
                       input bit wr, input bit sw, input int n, input int kind,
                       input bit stop_w_start, input string req);
    bit full = (code == 3'b111) && !(wr && sw);
    int bl   = full ? PAGE : ((wr && sw) ? 1 : bl_of(code));
    int beats = (kind == 0) ? bl : n;
    for (int k = 0; k < beats; k++) begin
      beat_t b;
      if (full)    b.col = (sc + k) % PAGE;
      else if (il) b.col = sc ^ k;
      else         b.col = (sc & ~(bl - 1)) | ((sc + k) % bl);
      b.last = !full && (k == bl - 1);
      b.req  = req;
      q.push_back(b);
    end
    start_i = 1'b1; start_col_i = COL_W'(sc); bl_code_i = code;
    interleave_i = il; write_i = wr; single_wr_i = sw; stop_i = stop_w_start;
    @(negedge clk_i);
    start_i = 1'b0; stop_i = 1'b0;
    repeat (beats - 1) @(negedge clk_i);
    if (kind == 1 || kind == 2) begin
      stop_i = (kind == 1); pre_i = (kind == 2);
      @(negedge clk_i);
      stop_i = 1'b0; pre_i = 1'b0;
    end
  endtask

  task automatic idle(input string req);
    @(negedge clk_i);
    chk(valid_o == 1'b0, req, "valid after end", int'(valid_o), 0);
    chk(q.size() == 0, req, "beats outstanding", q.size(), 0);
  endtask

  // monitor: pops one expected beat per valid cycle
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7", "unexpected beat col", int'(col_o), -1);
      end else begin
        beat_t e;
        e = q.pop_front();
        chk(int'(col_o) == e.col, e.req, "col", int'(col_o), e.col);
        chk(last_o == e.last, e.req, "last", int'(last_o), int'(e.last));
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(valid_o == 1'b0, "R1", "valid", int'(valid_o), 0);
    chk(last_o == 1'b0, "R1", "last", int'(last_o), 0);
    chk(col_o == '0, "R1", "col", int'(col_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R4 sequential at each length
    burst(8'h01, 3'b010, 0, 0, 0, 0, 0, 0, "R4"); idle("R7");
    burst(8'h2D, 3'b011, 0, 0, 0, 0, 0, 0, "R4"); idle("R7");
    burst(8'h11, 3'b001, 0, 0, 0, 0, 0, 0, "R4"); idle("R7");
    burst(8'h7F, 3'b000, 0, 0, 0, 0, 0, 0, "R3"); idle("R3");
    // R5 interleave
    burst(8'h45, 3'b011, 1, 0, 0, 0, 0, 0, "R5"); idle("R7");
    burst(8'h03, 3'b010, 1, 0, 0, 0, 0, 0, "R5"); idle("R7");
    // R3 reserved codes
    burst(8'h20, 3'b100, 0, 0, 0, 0, 0, 0, "R3"); idle("R3");
    burst(8'h21, 3'b101, 1, 0, 0, 0, 0, 0, "R3"); idle("R3");
    burst(8'h22, 3'b110, 0, 1, 0, 0, 0, 0, "R3"); idle("R3");
    // R6 full page wraps the row; stopped by R9
    burst(8'hFE, 3'b111, 0, 0, 0, 260, 1, 0, "R6"); idle("R9");
    burst(8'h05, 3'b111, 1, 0, 0, 6, 2, 0, "R6"); idle("R10");
    // R8 single-write override
    burst(8'h13, 3'b011, 0, 1, 1, 0, 0, 0, "R8"); idle("R8");
    burst(8'h13, 3'b011, 1, 0, 1, 0, 0, 0, "R8"); idle("R8");
    burst(8'h36, 3'b010, 0, 1, 0, 0, 0, 0, "R8"); idle("R8");
    burst(8'h40, 3'b111, 0, 1, 1, 0, 0, 0, "R8"); idle("R8");
    // R9 stop mid-burst, on first beat, and start winning over stop
    burst(8'h00, 3'b011, 0, 0, 0, 3, 1, 0, "R9"); idle("R9");
    burst(8'h90, 3'b111, 0, 0, 0, 1, 1, 0, "R9"); idle("R9");
    burst(8'h0A, 3'b010, 0, 0, 0, 0, 0, 1, "R9"); idle("R9");
    // R10 precharge interrupt
    burst(8'h5C, 3'b011, 1, 1, 0, 5, 2, 0, "R10"); idle("R10");
    // R2 restart during a burst, and back to back after a final beat
    burst(8'h18, 3'b011, 0, 0, 0, 3, 3, 0, "R2");
    burst(8'h81, 3'b010, 0, 0, 0, 0, 0, 0, "R2");
    burst(8'hC6, 3'b001, 1, 0, 0, 0, 0, 0, "R2"); idle("R2");
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule